// File: doc/BRIEF.md
# Process-Tagged Translation Cache with Mixed Page Sizes

This block is a small fully associative cache of address translations. Each entry holds a virtual page tag, a process identifier, a page-size code, a physical frame and a permission field. A lookup presents a virtual address and the identifier of the running process. One cycle later the block returns either a hit, with the translated physical address and the stored permission bits, or a miss. On a miss the requester walks the page tables and installs the result through the fill port. Because every entry is tagged with its process, entries from several processes can be held at the same time, and a context switch needs no flush.

An entry can map a 4 KB page, a 2 MB superpage or a 1 GB superpage. The tag compare ignores the address bits that fall inside the page. The physical address takes its high bits from the stored frame and its low bits from the virtual address, with the split set by the entry's size. When system software changes a mapping, it can remove one translation by address and process, or it can clear the whole cache.

Top module: `xlat_cache`

## Requirements
- R1: After a synchronous active-low reset, res_valid, res_hit, res_pa and res_perm are all zero and every entry is invalid, so the first lookup misses.
- R2: A lookup (lk_valid high for one cycle) produces exactly one result cycle with res_valid high in the next cycle. It hits when a valid entry has an equal process ID and an equal virtual tag on the compared bits.
- R3: An entry whose stored process ID differs from lk_pid never hits, even when its address matches.
- R4: Size code 00 compares VA bits 31..12, code 01 compares bits 31..21, and codes 10 and 11 compare bits 31..30. An address outside the covered range misses.
- R5: On a hit, res_pa takes bits above the size boundary from the stored frame (fill_frame is PA bits 31..12) and bits below it from lk_va.
- R6: On a hit, res_perm returns the stored permission field. On a miss, res_hit, res_pa and res_perm are all zero.
- R7: A fill goes into the lowest-numbered invalid entry. When all entries are valid, it evicts the entry at a round-robin pointer. The pointer starts at entry 0 after reset and advances by one only on such an eviction.
- R8: A fill whose size code, process ID and masked tag equal those of a valid entry overwrites that entry in place instead of taking a second one.
- R9: A single purge invalidates every valid entry whose process ID equals purge_pid and whose masked tag equals purge_vpn. All other entries are left untouched.
- R10: Purge-all invalidates every entry. A fill presented in the same cycle is discarded.
- R11: A lookup in the same cycle as a purge misses on the entries being purged. A lookup in the same cycle as a fill sees the contents from before the fill.
- R12: When several entries hit, the lowest-numbered one supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_pid | input | 8 | Process ID of the lookup |
| res_valid | output | 1 | Registered result strobe |
| res_hit | output | 1 | Lookup hit |
| res_pa | output | 32 | Translated physical address |
| res_perm | output | 3 | Stored permission field |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | 20 | Virtual address bits 31..12 of the fill |
| fill_pid | input | 8 | Process ID of the fill |
| fill_size | input | 2 | Page size code of the fill |
| fill_frame | input | 20 | Physical address bits 31..12 of the fill |
| fill_perm | input | 3 | Permission field of the fill |
| purge_valid | input | 1 | Invalidate matching translations |
| purge_vpn | input | 20 | Virtual address bits 31..12 to purge |
| purge_pid | input | 8 | Process ID to purge |
| purge_all | input | 1 | Invalidate all entries |

## Verification
Lookups are tried against 4 KB, 2 MB and 1 GB entries, both just inside and just outside the covered range. This separates the three compare masks and shows that code 11 is treated as a 1 GB page. Pairs of lookups that differ only in process ID show that the ID is part of the tag. An overlapping 1 GB and 4 KB pair, first with both present and then after one is purged, shows that the lower-numbered entry wins. A full table followed by evictions, a purge and more fills follows the round-robin pointer and the preference for invalid entries. Lookups issued in the same cycle as a purge, a fill or a purge-all show which contents each one sees.

// File: rtl/xlat_pkg.sv
// Shared definitions for the process-tagged translation cache.
// Assumes a 4 KB base page; size codes select the compare boundary.
package xlat_pkg;

    localparam int PG_LSB  = 12;  // lowest translated bit of a 4 KB page
    localparam int MID_LSB = 21;  // boundary of a 2 MB superpage
    localparam int BIG_LSB = 30;  // boundary of a 1 GB superpage

    typedef enum logic [1:0] {
        SZ_4K  = 2'b00,
        SZ_2M  = 2'b01,
        SZ_1G  = 2'b10,
        SZ_1GX = 2'b11
    } pg_size_e;

    // Bit position where the page offset ends for a given size code.
    function automatic int boundary_of(input logic [1:0] sz);
        case (sz)
            SZ_4K:   return PG_LSB;
            SZ_2M:   return MID_LSB;
            default: return BIG_LSB;
        endcase
    endfunction

endpackage

// File: rtl/xlat_entry.sv
// One translation slot: holds tag, process ID, size, frame and permission.
// Provides lookup, purge and duplicate matches against its own size mask,
// and composes the upper physical address bits for the lookup address.
// Assumes at most one of flush / write / purge takes effect per cycle,
// in that order of precedence.
module xlat_entry
    import xlat_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PID_W  = 8,
    parameter int PERM_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-PG_LSB-1:0] lk_vpn,
    input  logic [PID_W-1:0]         lk_pid,
    output logic                     lk_match,
    output logic [ADDR_W-PG_LSB-1:0] lk_frame,
    output logic [PERM_W-1:0]        lk_perm,
    input  logic                     pg_en,
    input  logic [ADDR_W-PG_LSB-1:0] pg_vpn,
    input  logic [PID_W-1:0]         pg_pid,
    output logic                     pg_match,
    input  logic                     flush,
    input  logic                     wr_en,
    input  logic [ADDR_W-PG_LSB-1:0] wr_vpn,
    input  logic [PID_W-1:0]         wr_pid,
    input  logic [1:0]               wr_size,
    input  logic [ADDR_W-PG_LSB-1:0] wr_frame,
    input  logic [PERM_W-1:0]        wr_perm,
    output logic                     dup_match,
    output logic                     valid_o
);
    localparam int VPN_W = ADDR_W - PG_LSB;

    logic              v_q;
    logic [VPN_W-1:0]  vpn_q;
    logic [PID_W-1:0]  pid_q;
    logic [1:0]        size_q;
    logic [VPN_W-1:0]  frame_q;
    logic [PERM_W-1:0] perm_q;
    logic [VPN_W-1:0]  cmp_mask;

    // Compare mask: ones on the VPN bits above this entry's page boundary.
    always_comb begin
        cmp_mask = {VPN_W{1'b1}} << (boundary_of(size_q) - PG_LSB);
    end

    // Match terms for lookup, purge and duplicate detection.
    always_comb begin
        lk_match  = v_q && (pid_q == lk_pid) && (((vpn_q ^ lk_vpn) & cmp_mask) == '0);
        pg_match  = pg_en && v_q && (pid_q == pg_pid) &&
                    (((vpn_q ^ pg_vpn) & cmp_mask) == '0);
        dup_match = v_q && (size_q == wr_size) && (pid_q == wr_pid) &&
                    (((vpn_q ^ wr_vpn) & cmp_mask) == '0);
        lk_frame  = (frame_q & cmp_mask) | (lk_vpn & ~cmp_mask);
        lk_perm   = perm_q;
        valid_o   = v_q;
    end

    // Valid bit: flush beats write, write beats single purge.
    always_ff @(posedge clk) begin
        if (!rst_n)        v_q <= 1'b0;
        else if (flush)    v_q <= 1'b0;
        else if (wr_en)    v_q <= 1'b1;
        else if (pg_match) v_q <= 1'b0;
    end

    // Payload storage, loaded on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q   <= '0;
            pid_q   <= '0;
            size_q  <= '0;
            frame_q <= '0;
            perm_q  <= '0;
        end else if (wr_en && !flush) begin
            vpn_q   <= wr_vpn;
            pid_q   <= wr_pid;
            size_q  <= wr_size;
            frame_q <= wr_frame;
            perm_q  <= wr_perm;
        end
    end

endmodule

// File: rtl/xlat_victim.sv
// Chooses the slot a fill writes: a matching duplicate first, then the
// lowest invalid slot, otherwise the round-robin pointer, which advances
// only when it was used. Output is one-hot or zero.
module xlat_victim #(
    parameter int N_ENT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             flush,
    input  logic [N_ENT-1:0] valid_vec,
    input  logic [N_ENT-1:0] dup_vec,
    output logic [N_ENT-1:0] wr_vec
);
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] pick;
    logic             use_rr;

    // Slot selection by priority: duplicate, then free slot, then pointer.
    always_comb begin
        logic found_dup;
        logic found_free;
        found_dup  = 1'b0;
        found_free = 1'b0;
        pick       = rr_q;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (dup_vec[i]) begin
                found_dup = 1'b1;
            end
        end
        if (found_dup) begin
            for (int i = N_ENT - 1; i >= 0; i--) begin
                if (dup_vec[i]) pick = IDX_W'(i);
            end
        end else begin
            for (int i = N_ENT - 1; i >= 0; i--) begin
                if (!valid_vec[i]) begin
                    pick       = IDX_W'(i);
                    found_free = 1'b1;
                end
            end
        end
        use_rr = !found_dup && !found_free;
        wr_vec = '0;
        if (req && !flush) wr_vec[pick] = 1'b1;
    end

    // Round-robin pointer moves on evictions only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (req && !flush && use_rr) begin
            if (rr_q == IDX_W'(N_ENT - 1)) rr_q <= '0;
            else                          rr_q <= rr_q + 1'b1;
        end
    end

endmodule

// File: rtl/xlat_outreg.sv
// Picks the lowest-numbered hitting slot and registers the lookup result.
// Misses return zero address and permission.
module xlat_outreg
    import xlat_pkg::*;
#(
    parameter int N_ENT  = 16,
    parameter int ADDR_W = 32,
    parameter int PERM_W = 3
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 lk_valid,
    input  logic [PG_LSB-1:0]                    lk_offset,
    input  logic [N_ENT-1:0]                     hit_vec,
    input  logic [N_ENT-1:0][ADDR_W-PG_LSB-1:0]  frame_arr,
    input  logic [N_ENT-1:0][PERM_W-1:0]         perm_arr,
    output logic                                 res_valid,
    output logic                                 res_hit,
    output logic [ADDR_W-1:0]                    res_pa,
    output logic [PERM_W-1:0]                    res_perm
);
    logic                     any_hit;
    logic [ADDR_W-PG_LSB-1:0] sel_frame;
    logic [PERM_W-1:0]        sel_perm;

    // Lowest index wins when several slots hit.
    always_comb begin
        any_hit   = 1'b0;
        sel_frame = '0;
        sel_perm  = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit   = 1'b1;
                sel_frame = frame_arr[i];
                sel_perm  = perm_arr[i];
            end
        end
    end

    // Result register, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_pa    <= '0;
            res_perm  <= '0;
        end else begin
            res_valid <= lk_valid;
            res_hit   <= lk_valid && any_hit;
            res_pa    <= (lk_valid && any_hit) ? {sel_frame, lk_offset} : '0;
            res_perm  <= (lk_valid && any_hit) ? sel_perm : '0;
        end
    end

endmodule

// File: rtl/xlat_cache.sv
// Top level: fully associative, process-tagged translation cache with
// 4 KB / 2 MB / 1 GB entries. A lookup result appears one cycle after the
// request. Fill, purge and purge-all take effect at the next clock edge.
// Assumes the requester handles misses with its own table walk.
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int N_ENT  = 16,
    parameter int ADDR_W = 32,
    parameter int PID_W  = 8,
    parameter int PERM_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lk_valid,
    input  logic [ADDR_W-1:0]        lk_va,
    input  logic [PID_W-1:0]         lk_pid,
    output logic                     res_valid,
    output logic                     res_hit,
    output logic [ADDR_W-1:0]        res_pa,
    output logic [PERM_W-1:0]        res_perm,
    input  logic                     fill_valid,
    input  logic [ADDR_W-PG_LSB-1:0] fill_vpn,
    input  logic [PID_W-1:0]         fill_pid,
    input  logic [1:0]               fill_size,
    input  logic [ADDR_W-PG_LSB-1:0] fill_frame,
    input  logic [PERM_W-1:0]        fill_perm,
    input  logic                     purge_valid,
    input  logic [ADDR_W-PG_LSB-1:0] purge_vpn,
    input  logic [PID_W-1:0]         purge_pid,
    input  logic                     purge_all
);
    localparam int VPN_W = ADDR_W - PG_LSB;

    logic [N_ENT-1:0]             lk_match;
    logic [N_ENT-1:0]             pg_match;
    logic [N_ENT-1:0]             dup_vec;
    logic [N_ENT-1:0]             valid_vec;
    logic [N_ENT-1:0]             ent_wr;
    logic [N_ENT-1:0]             hit_vec;
    logic [N_ENT-1:0][VPN_W-1:0]  frame_arr;
    logic [N_ENT-1:0][PERM_W-1:0] perm_arr;

    // Hits are suppressed on slots being purged in this same cycle.
    always_comb begin
        hit_vec = lk_match & ~pg_match & {N_ENT{~purge_all}};
    end

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        xlat_entry #(
            .ADDR_W (ADDR_W),
            .PID_W  (PID_W),
            .PERM_W (PERM_W)
        ) u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .lk_vpn    (lk_va[ADDR_W-1:PG_LSB]),
            .lk_pid    (lk_pid),
            .lk_match  (lk_match[g]),
            .lk_frame  (frame_arr[g]),
            .lk_perm   (perm_arr[g]),
            .pg_en     (purge_valid),
            .pg_vpn    (purge_vpn),
            .pg_pid    (purge_pid),
            .pg_match  (pg_match[g]),
            .flush     (purge_all),
            .wr_en     (ent_wr[g]),
            .wr_vpn    (fill_vpn),
            .wr_pid    (fill_pid),
            .wr_size   (fill_size),
            .wr_frame  (fill_frame),
            .wr_perm   (fill_perm),
            .dup_match (dup_vec[g]),
            .valid_o   (valid_vec[g])
        );
    end

    xlat_victim #(
        .N_ENT (N_ENT)
    ) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (fill_valid),
        .flush     (purge_all),
        .valid_vec (valid_vec),
        .dup_vec   (dup_vec),
        .wr_vec    (ent_wr)
    );

    xlat_outreg #(
        .N_ENT  (N_ENT),
        .ADDR_W (ADDR_W),
        .PERM_W (PERM_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_valid  (lk_valid),
        .lk_offset (lk_va[PG_LSB-1:0]),
        .hit_vec   (hit_vec),
        .frame_arr (frame_arr),
        .perm_arr  (perm_arr),
        .res_valid (res_valid),
        .res_hit   (res_hit),
        .res_pa    (res_pa),
        .res_perm  (res_perm)
    );

endmodule

// File: rtl/xlat_cache_chk.sv
// Property checker for xlat_cache, attached by bind below.
// Assumes synchronous active-low reset on rst_n.
module xlat_cache_chk
    import xlat_pkg::*;
#(
    parameter int N_ENT  = 16,
    parameter int ADDR_W = 32,
    parameter int PERM_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [ADDR_W-1:0] lk_va,
    input logic              purge_all,
    input logic              res_valid,
    input logic              res_hit,
    input logic [ADDR_W-1:0] res_pa,
    input logic [PERM_W-1:0] res_perm,
    input logic [N_ENT-1:0]  wr_vec
);
    AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid); // R2
    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid); // R2
    AST_HIT_NEEDS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_valid); // R2
    AST_MISS_IS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_pa == '0 && res_perm == '0)); // R6
    AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!res_hit || res_pa[PG_LSB-1:0] == $past(lk_va[PG_LSB-1:0]))); // R5
    AST_FLUSH_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && purge_all) |=> !res_hit); // R11
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && $past(purge_all)) |=> !res_hit); // R10
    AST_ONE_SLOT_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_vec)); // R7
    AST_FLUSH_DROPS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        purge_all |-> (wr_vec == '0)); // R10
endmodule

bind xlat_cache xlat_cache_chk #(
    .N_ENT  (N_ENT),
    .ADDR_W (ADDR_W),
    .PERM_W (PERM_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_va     (lk_va),
    .purge_all (purge_all),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_pa    (res_pa),
    .res_perm  (res_perm),
    .wr_vec    (ent_wr)
);

// File: tb/xlat_cache_bench.sv
// Scoreboard bench: lookup tasks queue expected results, a monitor on the
// falling edge pops and compares them against the registered outputs.
module xlat_cache_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid;
    logic [31:0] lk_va;
    logic [7:0]  lk_pid;
    logic        res_valid;
    logic        res_hit;
    logic [31:0] res_pa;
    logic [2:0]  res_perm;
    logic        fill_valid;
    logic [19:0] fill_vpn;
    logic [7:0]  fill_pid;
    logic [1:0]  fill_size;
    logic [19:0] fill_frame;
    logic [2:0]  fill_perm;
    logic        purge_valid;
    logic [19:0] purge_vpn;
    logic [7:0]  purge_pid;
    logic        purge_all;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic        q_hit[$];
    logic [31:0] q_pa[$];
    logic [2:0]  q_perm[$];
    string       q_tag[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    xlat_cache u_xlat_cache (
        .clk         (clk),
        .rst_n       (rst_n),
        .lk_valid    (lk_valid),
        .lk_va       (lk_va),
        .lk_pid      (lk_pid),
        .res_valid   (res_valid),
        .res_hit     (res_hit),
        .res_pa      (res_pa),
        .res_perm    (res_perm),
        .fill_valid  (fill_valid),
        .fill_vpn    (fill_vpn),
        .fill_pid    (fill_pid),
        .fill_size   (fill_size),
        .fill_frame  (fill_frame),
        .fill_perm   (fill_perm),
        .purge_valid (purge_valid),
        .purge_vpn   (purge_vpn),
        .purge_pid   (purge_pid),
        .purge_all   (purge_all)
    );

    task automatic clear_inputs();
        lk_valid = 0; lk_va = '0; lk_pid = '0;
        fill_valid = 0; fill_vpn = '0; fill_pid = '0; fill_size = '0;
        fill_frame = '0; fill_perm = '0;
        purge_valid = 0; purge_vpn = '0; purge_pid = '0; purge_all = 0;
    endtask

    // Advance one cycle (negedge to negedge) and drop all requests.
    task automatic tick();
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic set_lookup(input logic [31:0] va, input logic [7:0] pid,
                              input logic eh, input logic [31:0] epa,
                              input logic [2:0] eperm, input string tag);
        lk_valid = 1; lk_va = va; lk_pid = pid;
        q_hit.push_back(eh);
        q_pa.push_back(eh ? epa : 32'h0);
        q_perm.push_back(eh ? eperm : 3'h0);
        q_tag.push_back(tag);
    endtask

    task automatic set_fill(input logic [31:0] va, input logic [7:0] pid,
                            input logic [1:0] sz, input logic [19:0] frame,
                            input logic [2:0] perm);
        fill_valid = 1; fill_vpn = va[31:12]; fill_pid = pid;
        fill_size = sz; fill_frame = frame; fill_perm = perm;
    endtask

    task automatic set_purge(input logic [31:0] va, input logic [7:0] pid);
        purge_valid = 1; purge_vpn = va[31:12]; purge_pid = pid;
    endtask

    task automatic lookup(input logic [31:0] va, input logic [7:0] pid,
                          input logic eh, input logic [31:0] epa,
                          input logic [2:0] eperm, input string tag);
        set_lookup(va, pid, eh, epa, eperm, tag);
        tick();
    endtask

    task automatic fill(input logic [31:0] va, input logic [7:0] pid,
                        input logic [1:0] sz, input logic [19:0] frame,
                        input logic [2:0] perm);
        set_fill(va, pid, sz, frame, perm);
        tick();
    endtask

    task automatic purge(input logic [31:0] va, input logic [7:0] pid);
        set_purge(va, pid);
        tick();
    endtask

    // Monitor: compare each result strobe against the queued expectation.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && res_valid === 1'b1) begin
            n_chk++;
            if (q_hit.size() == 0) begin
                n_fail++;
                $display("FAIL R2 unexpected result hit=%0b pa=%h", res_hit, res_pa);
            end else begin
                logic        eh;
                logic [31:0] epa;
                logic [2:0]  ep;
                string       t;
                eh = q_hit.pop_front();
                epa = q_pa.pop_front();
                ep = q_perm.pop_front();
                t = q_tag.pop_front();
                if (res_hit !== eh || res_pa !== epa || res_perm !== ep) begin
                    n_fail++;
                    $display("FAIL %s actual hit=%0b pa=%h perm=%0d expected hit=%0b pa=%h perm=%0d",
                             t, res_hit, res_pa, res_perm, eh, epa, ep);
                end
            end
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        clear_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        n_chk++;
        if (res_valid !== 0 || res_hit !== 0 || res_pa !== 0 || res_perm !== 0) begin
            n_fail++;
            $display("FAIL R1 reset outputs actual v=%0b h=%0b pa=%h p=%0d expected all zero",
                     res_valid, res_hit, res_pa, res_perm);
        end
        rst_n = 1;
        lookup(32'h0000_1000, 8'd1, 0, 0, 0, "R1 empty after reset");

        // Basic 4 KB hit, process tag, neighbouring page
        fill(32'h1234_5000, 8'd1, 2'b00, 20'h0ABCD, 3'd3);
        lookup(32'h1234_5678, 8'd1, 1, 32'h0ABC_D678, 3'd3, "R2 R5 R6 4K hit");
        lookup(32'h1234_5678, 8'd2, 0, 0, 0, "R3 pid mismatch");
        lookup(32'h1234_6678, 8'd1, 0, 0, 0, "R4 next 4K page");

        // 2 MB superpage
        fill(32'h4060_0000, 8'd1, 2'b01, 20'h12345, 3'd5);
        lookup(32'h407F_FABC, 8'd1, 1, 32'h123F_FABC, 3'd5, "R4 R5 2M hit");
        lookup(32'h4080_0000, 8'd1, 0, 0, 0, "R4 beyond 2M");

        // 1 GB superpage, and code 11 treated as 1 GB
        fill(32'h8000_0000, 8'd7, 2'b10, 20'hC0000, 3'd1);
        lookup(32'hBFFF_F123, 8'd7, 1, 32'hFFFF_F123, 3'd1, "R4 R5 1G hit");
        lookup(32'hC000_0000, 8'd7, 0, 0, 0, "R4 beyond 1G");
        fill(32'h0000_0000, 8'd9, 2'b11, 20'h40000, 3'd2);
        lookup(32'h3ABC_DEF0, 8'd9, 1, 32'h7ABC_DEF0, 3'd2, "R4 code 11 as 1G");

        // Duplicate fill overwrites in place
        fill(32'h1234_5000, 8'd1, 2'b00, 20'h00077, 3'd6);
        lookup(32'h1234_5678, 8'd1, 1, 32'h0007_7678, 3'd6, "R8 duplicate overwrite");

        // Overlap: 1 GB (slot 2) shadows a 4 KB page (slot 4)
        fill(32'h8123_4000, 8'd7, 2'b00, 20'h00055, 3'd4);
        lookup(32'h8123_4ABC, 8'd7, 1, 32'hC123_4ABC, 3'd1, "R12 lowest index wins");

        // Single purge hits the 1 GB entry only
        purge(32'h9000_0000, 8'd7);
        lookup(32'h8123_4ABC, 8'd7, 1, 32'h0005_5ABC, 3'd4, "R9 R12 purged 1G, 4K remains");
        lookup(32'h1234_5678, 8'd1, 1, 32'h0007_7678, 3'd6, "R9 unrelated entry kept");
        purge(32'h4060_0000, 8'd2);
        lookup(32'h4060_0010, 8'd1, 1, 32'h1220_0010, 3'd5, "R9 other pid not purged");

        // Lookup together with purge, and together with fill
        set_lookup(32'h4060_0010, 8'd1, 0, 0, 0, "R11 lookup during purge");
        set_purge(32'h4070_0000, 8'd1);
        tick();
        lookup(32'h4060_0010, 8'd1, 0, 0, 0, "R9 stays purged");
        set_lookup(32'h5000_0000, 8'd3, 0, 0, 0, "R11 lookup during fill sees old");
        set_fill(32'h5000_0000, 8'd3, 2'b00, 20'h00321, 3'd7);
        tick();
        lookup(32'h5000_0000, 8'd3, 1, 32'h0032_1000, 3'd7, "R11 fill visible next cycle");

        // Purge-all with a fill in the same cycle
        purge_all = 1;
        set_fill(32'h6000_0000, 8'd3, 2'b00, 20'h00001, 3'd1);
        tick();
        lookup(32'h6000_0000, 8'd3, 0, 0, 0, "R10 fill dropped");
        lookup(32'h5000_0000, 8'd3, 0, 0, 0, "R10 cleared");
        lookup(32'h1234_5678, 8'd1, 0, 0, 0, "R10 cleared");

        // Replacement order
        for (int i = 0; i < 16; i++) begin
            fill(32'h2000_0000 + 32'(i) * 32'h1000, 8'd4, 2'b00, 20'(32'h100 + i), 3'(i));
        end
        fill(32'h2001_0000, 8'd4, 2'b00, 20'h1FF, 3'd0);
        lookup(32'h2000_00AB, 8'd4, 0, 0, 0, "R7 slot 0 evicted first");
        lookup(32'h2000_10AB, 8'd4, 1, 32'h0010_10AB, 3'd1, "R7 slot 1 kept");
        lookup(32'h2001_00AB, 8'd4, 1, 32'h001F_F0AB, 3'd0, "R7 new entry hits");
        fill(32'h2001_1000, 8'd4, 2'b00, 20'h1FE, 3'd0);
        lookup(32'h2000_10AB, 8'd4, 0, 0, 0, "R7 pointer advanced to slot 1");
        lookup(32'h2000_20AB, 8'd4, 1, 32'h0010_20AB, 3'd2, "R7 slot 2 kept");
        purge(32'h2000_5000, 8'd4);
        fill(32'h2001_2000, 8'd4, 2'b00, 20'h1FD, 3'd0);
        lookup(32'h2000_20AB, 8'd4, 1, 32'h0010_20AB, 3'd2, "R7 free slot preferred");
        lookup(32'h2001_20AB, 8'd4, 1, 32'h001F_D0AB, 3'd0, "R7 filled freed slot");
        fill(32'h2001_3000, 8'd4, 2'b00, 20'h1FC, 3'd0);
        lookup(32'h2000_20AB, 8'd4, 0, 0, 0, "R7 pointer held then evicts slot 2");
        lookup(32'h2000_30AB, 8'd4, 1, 32'h0010_30AB, 3'd3, "R7 slot 3 kept");

        repeat (3) @(negedge clk);
        n_chk++;
        if (q_hit.size() != 0) begin
            n_fail++;
            $display("FAIL R2 missing results actual %0d pending expected 0", q_hit.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule